// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block runs the reset and presence-detect phase of a 1-Wire bus through a discrete line driver. It drives two control pins: `drive`, active high, which pulls the line low through the driver's pull-down transistor. It also drives `dpu_n`, active low, which turns on a fast dynamic pull-up for a short, timed burst. The block reads the line back on `sense_in`. All timing is counted in clock cycles. The parameter `CLK_PER_US` gives the number of clock cycles in one microsecond, and each interval is written as a parameter in microseconds.

A one-cycle `start` begins a sequence, and a one-cycle `done` ends it. The sequence holds the line low for the reset interval and then releases it. The block then waits for the line to read high, so a slave that stretches the reset is absorbed. Next it gives a short pull-up burst and samples for a presence pulse. A later check sample catches an interrupt pulse from a slave; when one is seen, the block goes back to waiting for the line to rise. Once the line is clean, a longer pull-up burst and a short tail lead to `done`.

A watchdog runs from `start`. If the line never rises before it expires, the sequence ends with the short flag set. Only the presence and short results are reported. Both are held from `done` until the next accepted `start`.

Top module: `owire_rst_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `drive`=0, `dpu_n`=1, `done`=0, `presence`=0 and `short_flag`=0.
- R2: A `start` seen in idle makes `drive` high for exactly `RST_LOW_US*CLK_PER_US` cycles, beginning on the next clock edge; `drive` then returns low.
- R3: After `drive` is released, `dpu_n` stays high while the line reads low. `dpu_n` falls on the third rising edge at which `sense_in` is high (two synchroniser flops plus one state register), so a slave holding the line low lengthens the reset.
- R4: The first pull-up burst after the line reads high holds `dpu_n` low for exactly `FIRST_PU_US*CLK_PER_US` cycles.
- R5: The line is sampled `PRES_AT_US` after that burst starts. A low reading gives `presence`=1 at `done`, a high reading gives 0, and the last pass through the sequence decides the value.
- R6: A second sample `IRQ_AT_US` after the presence sample that reads low counts as an interrupt pulse. The block then returns to waiting for the line to rise, and a new first-type burst of `FIRST_PU_US` follows.
- R7: When the second sample reads high, `dpu_n` is low for exactly `LAST_PU_US*CLK_PER_US` cycles. `dpu_n` then stays high for exactly `TAIL_US*CLK_PER_US` cycles before `done` rises, and `done` lasts one cycle.
- R8: `drive` high and `dpu_n` low never occur in the same cycle; in the cycle of `done` and afterwards in idle, `drive`=0 and `dpu_n`=1.
- R9: If the line is still low when `WDOG_US*CLK_PER_US` cycles have passed since the `start` edge, `done` rises exactly that many cycles after `drive` rose, with `short_flag`=1 and `presence`=0; otherwise `short_flag`=0.
- R10: `presence` and `short_flag` keep their `done` values until the next accepted `start`, which clears both on its clock edge.
- R11: A `start` that arrives while a sequence is running is ignored: `drive` rises only once per sequence and its width is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run one reset/presence sequence |
| sense_in | input | 1 | Bus line level, asynchronous |
| drive | output | 1 | Pull-down enable, active high |
| dpu_n | output | 1 | Dynamic pull-up enable, active low |
| done | output | 1 | One-cycle end-of-sequence pulse |
| presence | output | 1 | A device answered during the last pass |
| short_flag | output | 1 | The line stayed low until the watchdog expired |

## Verification
Each pulse width is measured in whole cycles at falling clock edges and compared with the exact product of the microsecond parameter and `CLK_PER_US`. The gap from the release of `drive` to the first fall of `dpu_n` is due exactly two cycles after the modelled slave lets go (three when it never pulls). The time from the rise of `dpu_n` to `done` is due after the tail length, and `done` on the watchdog path after the full watchdog count from the rise of `drive`. A bus model in the bench places its presence and interrupt pulses tens of microseconds around each sample point, so those results do not depend on the exact sample cycle. The flags are checked in the cycle after `done` and again twenty cycles later.

// File: rtl/owire_rst_seq.sv
module owire_rst_seq #(
  parameter int CLK_PER_US  = 50,
  parameter int RST_LOW_US  = 480,
  parameter int FIRST_PU_US = 8,
  parameter int PRES_AT_US  = 72,
  parameter int IRQ_AT_US   = 240,
  parameter int LAST_PU_US  = 60,
  parameter int TAIL_US     = 2,
  parameter int WDOG_US     = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sense_in,
  output logic drive,
  output logic dpu_n,
  output logic done,
  output logic presence,
  output logic short_flag
);

  localparam int LOW_C  = RST_LOW_US  * CLK_PER_US;
  localparam int PU1_C  = FIRST_PU_US * CLK_PER_US;
  localparam int PRES_C = PRES_AT_US  * CLK_PER_US;
  localparam int IRQ_C  = IRQ_AT_US   * CLK_PER_US;
  localparam int PU2_C  = LAST_PU_US  * CLK_PER_US;
  localparam int TAIL_C = TAIL_US     * CLK_PER_US;
  localparam int WD_C   = WDOG_US     * CLK_PER_US;
  localparam int CW     = $clog2(WD_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_WAITHI, S_PU1, S_PRES, S_IRQ, S_PU2, S_TAIL
  } st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt, wd;
  logic          pres_s;
  logic          bus_hi;

  assign bus_hi = sync[1];
  assign drive  = (st == S_LOW);
  assign dpu_n  = !(st == S_PU1 || st == S_PU2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sync       <= 2'b00;
      cnt        <= '0;
      wd         <= '0;
      pres_s     <= 1'b0;
      done       <= 1'b0;
      presence   <= 1'b0;
      short_flag <= 1'b0;
    end else begin
      sync <= {sync[0], sense_in};
      done <= 1'b0;
      cnt  <= cnt + CW'(1);
      if (st != S_IDLE && wd != CW'(WD_C - 1)) wd <= wd + CW'(1);
      case (st)
        S_IDLE: if (start) begin
          st         <= S_LOW;
          cnt        <= '0;
          wd         <= '0;
          pres_s     <= 1'b0;
          presence   <= 1'b0;
          short_flag <= 1'b0;
        end
        S_LOW: if (cnt == CW'(LOW_C - 1)) begin
          st  <= S_WAITHI;
          cnt <= '0;
        end
        S_WAITHI: if (bus_hi) begin
          st  <= S_PU1;
          cnt <= '0;
        end else if (wd == CW'(WD_C - 1)) begin
          st         <= S_IDLE;
          done       <= 1'b1;
          short_flag <= 1'b1;
          presence   <= 1'b0;
        end
        S_PU1: if (cnt == CW'(PU1_C - 1)) st <= S_PRES;
        S_PRES: if (cnt == CW'(PRES_C - 1)) begin
          pres_s <= !bus_hi;
          st     <= S_IRQ;
          cnt    <= '0;
        end
        S_IRQ: if (cnt == CW'(IRQ_C - 1)) begin
          st  <= bus_hi ? S_PU2 : S_WAITHI;
          cnt <= '0;
        end
        S_PU2: if (cnt == CW'(PU2_C - 1)) begin
          st  <= S_TAIL;
          cnt <= '0;
        end
        S_TAIL: if (cnt == CW'(TAIL_C - 1)) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          presence <= pres_s;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] drv_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_run <= '0;
    else        drv_run <= drive ? drv_run + CW'(1) : '0;
  end

  AST_DRIVE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive) |-> drv_run == CW'(LOW_C)); // R2
  AST_PU_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpu_n) |-> $past(bus_hi)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!drive && dpu_n)); // R8
  AST_SHORT_NO_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    short_flag |-> !presence); // R9
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(st == S_IDLE)); // R11

endmodule

// File: tb/test_owire_rst_seq.sv
module test_owire_rst_seq;
  localparam int K = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pull = 1'b0;
  logic sense_in, drive, dpu_n, done, presence, short_flag;
  int total = 0, bad = 0, cyc = 0, viol = 0;

  assign sense_in = !drive && !pull;

  owire_rst_seq #(.CLK_PER_US(K)) i_owire_rst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sense_in(sense_in),
    .drive(drive), .dpu_n(dpu_n), .done(done),
    .presence(presence), .short_flag(short_flag));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && drive && !dpu_n) viol++;
    if (cyc > 200000) begin
      bad++;
      total++;
      $display("FAIL timeout actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int s, input bit pres, input bit irq, input bit stuck);
    int drw = 0, rises = 0, gap = 0, started = 0, curw = 0, tk = 0;
    int dcnt = 0, tail = 0, since = 0, guard = 0;
    int wid[4] = '{0, 0, 0, 0};
    bit fell = 0, prev_drv = 0, prev_pn = 1, stretch, pw, iw;
    @(negedge clk);
    start = 1'b1;
    pull  = (s > 0) || stuck;
    @(negedge clk);
    start = 1'b0;
    chk(presence == 0 && short_flag == 0, "R10 flags cleared by start",
        {presence, short_flag}, 0);
    while (!done && guard < 20000) begin
      guard++;
      since++;
      if (drive) begin
        drw++;
        if (!prev_drv) rises++;
      end
      if (prev_drv && !drive) fell = 1;
      if (fell) dcnt++;
      if (fell && started == 0 && dpu_n) gap++;
      if (!dpu_n) begin
        if (prev_pn) begin started++; tk = 0; curw = 0; end
        curw++;
      end else if (!prev_pn) begin
        wid[started-1] = curw;
        tail = 0;
      end
      if (dpu_n && started > 0) tail++;
      stretch = fell ? (dcnt < s) : (s > 0);
      pw = pres && (started == 1 || (irq && started == 2)) && tk >= 20*K && tk < 120*K;
      iw = irq && started == 1 && tk >= 290*K && tk < 420*K;
      pull  = stuck || stretch || pw || iw;
      start = (since == 100 || since == 1500);
      prev_drv = drive;
      prev_pn  = dpu_n;
      tk++;
      @(negedge clk);
    end
    start = 1'b0;
    pull  = 1'b0;
    chk(drw == 480*K, "R2 drive width", drw, 480*K);
    chk(rises == 1, "R11 drive rises once despite busy start", rises, 1);
    if (stuck) begin
      chk(since == 5000*K, "R9 watchdog done time", since, 5000*K);
      chk(short_flag == 1, "R9 short set", short_flag, 1);
      chk(presence == 0, "R9 presence clear on short", presence, 0);
      chk(started == 0, "R3 no pull-up while line low", started, 0);
    end else begin
      chk(gap == ((s <= 1) ? 3 : s + 2), "R3 release to pull-up gap", gap, (s <= 1) ? 3 : s + 2);
      chk(wid[0] == 8*K, "R4 first burst width", wid[0], 8*K);
      chk(started == (irq ? 3 : 2), "R6 burst count", started, irq ? 3 : 2);
      if (irq) chk(wid[1] == 8*K, "R6 burst after interrupt", wid[1], 8*K);
      chk(wid[started-1] == 60*K, "R7 last burst width", wid[started-1], 60*K);
      chk(tail == 2*K, "R7 tail length", tail, 2*K);
      chk(presence == pres, "R5 presence result", presence, pres);
      chk(short_flag == 0, "R9 short clear", short_flag, 0);
    end
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
    chk(!drive && dpu_n, "R8 idle pins", {drive, dpu_n}, 1);
    repeat (20) @(negedge clk);
    chk(presence == (stuck ? 0 : pres) && short_flag == stuck, "R10 flags held",
        {presence, short_flag}, {(stuck ? 1'b0 : pres), stuck});
  endtask

  initial begin
    int ss[4] = '{0, 1, 6, 30};
    repeat (3) @(negedge clk);
    chk(!drive && dpu_n && !done && !presence && !short_flag, "R1 in reset",
        {drive, dpu_n, done, presence, short_flag}, 5'b01000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive && dpu_n && !done && !presence && !short_flag, "R1 after reset",
        {drive, dpu_n, done, presence, short_flag}, 5'b01000);
    for (int i = 0; i < 4; i++)
      for (int p = 0; p < 2; p++)
        for (int q = 0; q < 2; q++)
          run(ss[i], p[0], q[0], 1'b0);
    run(0, 1'b1, 1'b0, 1'b1);
    run(0, 1'b1, 1'b0, 1'b0);
    chk(viol == 0, "R8 drive and pull-up never together", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule